// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down-counters. All three advance on a shared count-enable strobe, which stands for a fixed 1.19318 MHz timebase. A 2-bit address picks the port. Addresses 0, 1 and 2 are the byte-wide data ports of channels 0, 1 and 2, and address 3 is the control port. Reads and writes are single-cycle strobes.

A control write either freezes a snapshot of a channel's count or sets that channel's operating mode. Three modes are supported:

- A one-shot mode: the output rises when the count ends and the channel stops.
- Two periodic modes: the channel reloads by itself and keeps running.

Counts are loaded and read back as two bytes, low byte first. Each channel drives an output level and, on every expiry, a one-cycle interrupt pulse on its own bit. Software uses the block as a periodic tick source or as a one-shot delay. The snapshot lets it read a stable 16-bit value from a channel that is still counting.

Top module: `pit_timer3`

## Requirements
- R1: After reset every output, interrupt and the error flag are low, every channel is idle in mode 0, and each data port reads 0x00 then 0x00.
- R2: A control word has bits [7:6] as channel, [5:4] as access (00 = snapshot, 11 = low-then-high), [3:1] as mode and bit [0] as BCD. Address 3 is the control port and addresses 0 to 2 are the data ports of channels 0 to 2.
- R3: A low-byte data write stops the channel and drives its output low at once. The following high-byte write completes the 16-bit count and restarts the channel.
- R4: In mode 0 (code 000) with count N, the channel reads N right after loading. After N ticks the output goes high, one interrupt is raised, and the channel stops and reads 0.
- R5: In mode 2 (code 010) and mode 3 (code 011) with count N, the channel expires every N-1 ticks, reloads by itself and keeps running. Its output stays low.
- R6: In the periodic modes the reported count is the remaining ticks plus one. In mode 0 it is the remaining ticks. An idle channel reads 0.
- R7: Data reads alternate low byte then high byte.
- R8: A snapshot command freezes the count and moves the read pointer to the low byte. Reading the high byte releases it. A further snapshot while one is held is ignored.
- R9: A control word with channel 3, an access field other than 00 or 11, a mode other than 0, 2 or 3, or BCD set raises a sticky error flag. It leaves the channel's mode unchanged, and only reset clears the flag.
- R10: A load whose period is zero does not start the channel. This covers count 0 in mode 0 and count 1 in modes 2 and 3.
- R11: Each expiry raises a one-cycle pulse only on the interrupt bit of the channel that expired, in the cycle after the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe from the timebase |
| addr_i | input | 2 | Port select: 0-2 data, 3 control |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during the read strobe |
| out_o | output | 3 | Channel output levels |
| irq_o | output | 3 | Per-channel expiry pulses |
| err_o | output | 1 | Sticky unsupported-setting flag |

## Verification
The checker assumes that the count-enable strobe never stays high on two cycles in a row. Without that, a periodic channel with period 1 could pulse its interrupt on back-to-back cycles. The bench drives every tick as a single cycle followed by at least one idle cycle.

The checker also assumes that register writes and reads never fall in the same cycle as a tick that would expire the channel being accessed. The stimulus keeps every data access and control write in the gaps between tick sequences.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [1:0] {
      MODE_ONESHOT = 2'd0,
      MODE_RATE    = 2'd2,
      MODE_SQUARE  = 2'd3
   } pit_mode_e;

   localparam logic [1:0] ACC_SNAP = 2'b00;
   localparam logic [1:0] ACC_LOHI = 2'b11;
   localparam logic [1:0] SEL_RSVD = 2'b11;

   function automatic logic mode_periodic(pit_mode_e m);
      return (m == MODE_RATE) || (m == MODE_SQUARE);
   endfunction
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              wr_en,
   input  logic [7:0]        cword,
   output logic [NUM_CH-1:0] snap_req,
   output logic [NUM_CH-1:0] prog_req,
   output pit_mode_e         prog_mode,
   output logic              err_set
);
   logic [1:0] sel;
   logic [1:0] acc;
   logic [2:0] mcode;
   logic       bcd;
   logic       mode_ok;
   logic       sel_ok;

   assign sel     = cword[7:6];
   assign acc     = cword[5:4];
   assign mcode   = cword[3:1];
   assign bcd     = cword[0];
   assign mode_ok = (mcode == 3'd0) || (mcode == 3'd2) || (mcode == 3'd3);
   assign sel_ok  = (sel != SEL_RSVD) && (int'(sel) < NUM_CH);
   assign prog_mode = pit_mode_e'(mcode[1:0]);

   always_comb begin
      snap_req = '0;
      prog_req = '0;
      err_set  = 1'b0;
      if (wr_en) begin
         if (!sel_ok) begin
            err_set = 1'b1;
         end else if (acc == ACC_SNAP) begin
            snap_req[sel] = 1'b1;
         end else if ((acc == ACC_LOHI) && mode_ok && !bcd) begin
            prog_req[sel] = 1'b1;
         end else begin
            err_set = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              snap_req,
   input  logic              prog_req,
   input  pit_mode_e         prog_mode,
   output logic [DATA_W-1:0] rdata,
   output logic              out_lvl,
   output logic              irq
);
   localparam int CNT_W = 2 * DATA_W;

   pit_mode_e         mode_q;
   logic [CNT_W-1:0]  load_q;
   logic [CNT_W-1:0]  period_q;
   logic [CNT_W-1:0]  remain_q;
   logic [CNT_W-1:0]  snap_q;
   logic              run_q;
   logic              out_q;
   logic              irq_q;
   logic              snap_on_q;
   logic              rd_hi_q;
   logic              wr_hi_q;

   logic              periodic;
   logic [CNT_W-1:0]  live;
   logic [CNT_W-1:0]  rd_src;
   logic [CNT_W-1:0]  new_load;
   logic [CNT_W-1:0]  new_period;

   assign periodic   = mode_periodic(mode_q);
   assign live       = !run_q ? '0 : (periodic ? remain_q + CNT_W'(1) : remain_q);
   assign rd_src     = snap_on_q ? snap_q : live;
   assign rdata      = rd_hi_q ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
   assign new_load   = {wdata, load_q[DATA_W-1:0]};
   assign new_period = periodic ? new_load - CNT_W'(1) : new_load;
   assign out_lvl    = out_q;
   assign irq        = irq_q;

   // snapshot and read pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q    <= '0;
         snap_on_q <= 1'b0;
         rd_hi_q   <= 1'b0;
      end else if (snap_req && !snap_on_q) begin
         snap_q    <= live;
         snap_on_q <= 1'b1;
         rd_hi_q   <= 1'b0;
      end else if (rd_en) begin
         rd_hi_q <= !rd_hi_q;
         if (snap_on_q && rd_hi_q) snap_on_q <= 1'b0;
      end
   end

   // mode register
   always_ff @(posedge clk) begin
      if (!rst_n)        mode_q <= MODE_ONESHOT;
      else if (prog_req) mode_q <= prog_mode;
   end

   // load sequencing and counting; a data write wins over a tick
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q   <= '0;
         period_q <= '0;
         remain_q <= '0;
         run_q    <= 1'b0;
         out_q    <= 1'b0;
         irq_q    <= 1'b0;
         wr_hi_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wr_en && !wr_hi_q) begin
            load_q[DATA_W-1:0] <= wdata;
            run_q    <= 1'b0;
            out_q    <= 1'b0;
            remain_q <= '0;
            wr_hi_q  <= 1'b1;
         end else if (wr_en) begin
            load_q[CNT_W-1:DATA_W] <= wdata;
            period_q <= new_period;
            wr_hi_q  <= 1'b0;
            if (new_period != '0) begin
               run_q    <= 1'b1;
               remain_q <= new_period;
            end
         end else if (run_q && tick) begin
            if (remain_q == CNT_W'(1)) begin
               irq_q <= 1'b1;
               if (periodic) begin
                  remain_q <= period_q;
               end else begin
                  run_q    <= 1'b0;
                  out_q    <= 1'b1;
                  remain_q <= '0;
               end
            end else begin
               remain_q <= remain_q - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pit_timer3.sv
module pit_timer3
   import pit_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [NUM_CH-1:0] out_o,
   output logic [NUM_CH-1:0] irq_o,
   output logic              err_o
);
   localparam int CTRL_ADDR = NUM_CH;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("pit_timer3: NUM_CH must be 1 to 3");
   end
   if ((1 << ADDR_W) < NUM_CH + 1) begin : g_bad_addr
      $error("pit_timer3: ADDR_W too narrow for data and control ports");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("pit_timer3: DATA_W must be 8 to carry the control word");
   end

   logic              ctrl_wr;
   logic [NUM_CH-1:0] snap_req;
   logic [NUM_CH-1:0] prog_req;
   pit_mode_e         prog_mode;
   logic              err_set;
   logic              err_q;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];

   assign ctrl_wr = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));

   pit_ctrl_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_en     (ctrl_wr),
      .cword     (wdata_i[7:0]),
      .snap_req  (snap_req),
      .prog_req  (prog_req),
      .prog_mode (prog_mode),
      .err_set   (err_set)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel_here;
      assign sel_here = (addr_i == ADDR_W'(g));
      pit_channel #(.DATA_W(DATA_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick_i),
         .wr_en     (wr_i && sel_here),
         .rd_en     (rd_i && sel_here),
         .wdata     (wdata_i),
         .snap_req  (snap_req[g]),
         .prog_req  (prog_req[g]),
         .prog_mode (prog_mode),
         .rdata     (ch_rdata[g]),
         .out_lvl   (out_o[g]),
         .irq       (irq_o[g])
      );
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_i == ADDR_W'(i)) rdata_o = ch_rdata[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
   end
   assign err_o = err_q;
endmodule

// File: rtl/pit_timer3_chk.sv
module pit_timer3_chk #(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              wr_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [1:0]        cmd_sel,
   input logic [NUM_CH-1:0] out_o,
   input logic [NUM_CH-1:0] irq_o,
   input logic              err_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
      // R11
      irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[g] |=> !irq_o[g]);
      // R11
      irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[g] |-> $past(tick_i));
      // R4
      out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_o[g]) |-> irq_o[g]);
      // R3
      out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(out_o[g]) |-> $past(wr_i && (addr_i == ADDR_W'(g))));
   end

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   // R9
   err_rsvd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (addr_i == ADDR_W'(NUM_CH)) && (cmd_sel == 2'b11)) |=> err_o);
endmodule

bind pit_timer3 pit_timer3_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_i  (tick_i),
   .wr_i    (wr_i),
   .addr_i  (addr_i),
   .cmd_sel (wdata_i[7:6]),
   .out_o   (out_o),
   .irq_o   (irq_o),
   .err_o   (err_o)
);

// File: tb/pit_timer3_tb.sv
module pit_timer3_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic       wr_i = 1'b0;
   logic       rd_i = 1'b0;
   logic [7:0] wdata_i = 8'd0;
   logic [7:0] rdata_o;
   logic [2:0] out_o;
   logic [2:0] irq_o;
   logic       err_o;

   int n_chk = 0;
   int n_fail = 0;
   int irq_cnt [3];
   bit done = 0;

   pit_timer3 u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
      .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .out_o(out_o), .irq_o(irq_o), .err_o(err_o)
   );

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 3; i++) irq_cnt[i] += int'(irq_o[i]);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < 3; i++) irq_cnt[i] = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1 addr_i = a; wdata_i = d; wr_i = 1'b1;
      @(posedge clk); #1 wr_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(posedge clk); #1 addr_i = a; rd_i = 1'b1;
      #1 v = int'(rdata_o);
      @(posedge clk); #1 rd_i = 1'b0;
   endtask

   task automatic rd16(input logic [1:0] a, output int v);
      int lo, hi;
      rd(a, lo);
      rd(a, hi);
      v = (hi << 8) | lo;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1 tick_i = 1'b1;
         @(posedge clk); #1 tick_i = 1'b0;
      end
      @(posedge clk); #1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int v, v2, base;
      do_reset();

      // R1 reset state
      check("R1 out", int'(out_o), 0);
      check("R1 irq", int'(irq_o), 0);
      check("R1 err", int'(err_o), 0);
      for (int c = 0; c < 3; c++) begin
         rd16(2'(c), v);
         check("R1 R6 idle read", v, 0);
      end

      // R4 mode 0 sweep on channel 0
      for (int n = 1; n <= 8; n++) begin
         base = irq_cnt[0];
         wr(2'd3, 8'h30);
         wr(2'd0, 8'(n));
         wr(2'd0, 8'h00);
         rd16(2'd0, v);
         check("R4 loaded count", v, n);
         ticks(n - 1);
         check("R4 out before end", int'(out_o[0]), 0);
         rd16(2'd0, v);
         check("R4 R6 last count", v, 1);
         ticks(1);
         check("R4 out after end", int'(out_o[0]), 1);
         check("R4 R11 irq ch0", irq_cnt[0] - base, 1);
         check("R11 no irq ch1 ch2", irq_cnt[1] + irq_cnt[2], 0);
         rd16(2'd0, v);
         check("R4 R6 stopped reads 0", v, 0);
      end

      // R5 periodic sweep: channel 1 mode 2, channel 2 mode 3
      wr(2'd3, 8'h74);
      wr(2'd3, 8'hB6);
      for (int c = 1; c <= 2; c++) begin
         for (int n = 2; n <= 6; n++) begin
            base = irq_cnt[c];
            wr(2'(c), 8'(n));
            wr(2'(c), 8'h00);
            rd16(2'(c), v);
            check("R6 periodic loaded count", v, n);
            ticks(n - 2);
            check("R5 no early irq", irq_cnt[c] - base, 0);
            rd16(2'(c), v);
            check("R6 periodic count before expiry", v, 2);
            ticks(1);
            check("R5 R11 first expiry", irq_cnt[c] - base, 1);
            rd16(2'(c), v);
            check("R5 R6 reload", v, n);
            ticks(2 * (n - 1));
            check("R5 repeated expiry", irq_cnt[c] - base, 3);
            check("R5 out low", int'(out_o[c]), 0);
         end
      end

      // R10 periodic count 1 gives period 0: stops
      base = irq_cnt[1];
      wr(2'd1, 8'h01);
      wr(2'd1, 8'h00);
      rd16(2'd1, v);
      check("R10 count1 idle", v, 0);
      ticks(5);
      check("R10 count1 no irq", irq_cnt[1] - base, 0);

      // R10 mode 0 count 0 on channel 2
      wr(2'd3, 8'hB0);
      base = irq_cnt[2];
      wr(2'd2, 8'h00);
      wr(2'd2, 8'h00);
      rd16(2'd2, v);
      check("R10 count0 idle", v, 0);
      ticks(4);
      check("R10 count0 no irq", irq_cnt[2] - base, 0);

      // R3 low byte stops and clears output (channel 0 out is high now)
      base = irq_cnt[0];
      wr(2'd0, 8'h04);
      check("R3 out low after low byte", int'(out_o[0]), 0);
      ticks(6);
      check("R3 stopped no irq", irq_cnt[0] - base, 0);
      rd16(2'd0, v);
      check("R3 stopped reads 0", v, 0);
      wr(2'd0, 8'h00);
      rd16(2'd0, v);
      check("R3 restart count", v, 4);
      ticks(2);
      wr(2'd0, 8'h09);
      ticks(5);
      check("R3 midrun stop", irq_cnt[0] - base, 0);
      wr(2'd0, 8'h00);
      rd16(2'd0, v);
      check("R3 reload after stop", v, 9);

      // R7 two-byte order with a nonzero high byte
      wr(2'd3, 8'hB0);
      wr(2'd2, 8'h34);
      wr(2'd2, 8'h12);
      rd(2'd2, v);
      check("R7 low byte", v, 'h34);
      rd(2'd2, v);
      check("R7 high byte", v, 'h12);

      // R8 snapshot on channel 1 in mode 2
      wr(2'd3, 8'h74);
      wr(2'd1, 8'd100);
      wr(2'd1, 8'h00);
      ticks(4);
      wr(2'd3, 8'h40);
      ticks(5);
      wr(2'd3, 8'h40);
      rd(2'd1, v);
      check("R8 frozen low byte", v, 96);
      ticks(1);
      rd(2'd1, v);
      check("R8 frozen high byte", v, 0);
      rd16(2'd1, v);
      check("R8 released live", v, 90);
      rd(2'd1, v);
      check("R7 live low", v, 90);
      wr(2'd3, 8'h40);
      ticks(2);
      rd(2'd1, v);
      check("R8 pointer reset to low", v, 90);
      rd(2'd1, v2);
      check("R8 high after reset pointer", v2, 0);
      rd16(2'd1, v);
      check("R8 live after release", v, 88);

      // R9 BCD set: error, mode stays 0
      do_reset();
      wr(2'd3, 8'h35);
      check("R9 bcd error", int'(err_o), 1);
      base = irq_cnt[0];
      wr(2'd0, 8'h03);
      wr(2'd0, 8'h00);
      ticks(2);
      check("R9 mode kept no irq", irq_cnt[0] - base, 0);
      check("R9 mode kept out low", int'(out_o[0]), 0);
      ticks(1);
      check("R9 mode kept out high", int'(out_o[0]), 1);
      check("R9 sticky", int'(err_o), 1);

      // R9 bad access field
      do_reset();
      wr(2'd3, 8'h12);
      check("R9 access error", int'(err_o), 1);
      // R9 R2 reserved channel select
      do_reset();
      check("R9 cleared by reset", int'(err_o), 0);
      wr(2'd3, 8'hF4);
      check("R9 R2 channel 3 error", int'(err_o), 1);
      // R9 mode 6
      do_reset();
      wr(2'd3, 8'h3C);
      check("R9 mode 6 error", int'(err_o), 1);
      ticks(3);
      check("R9 sticky after ticks", int'(err_o), 1);

      done = 1;
      summary();
      $finish;
   end
endmodule